// File: doc/BRIEF.md
# Selectable Write-Policy Direct-Mapped Cache Controller

This block is a direct-mapped data cache controller. It sits between a single CPU request port and a memory port that moves whole lines. Two elaboration parameters choose its behaviour on stores, and they are independent of each other. `WRITE_BACK` decides what a store that hits does: it either updates only the cache and marks the line modified, or it updates the cache and also sends the word on to memory. `WRITE_ALLOC` decides what a store that misses does: it either brings the line in first and then merges the store, or it sends the word straight to memory and leaves the cache alone.

Each line keeps a tag and a valid bit. A modified (dirty) bit exists only when `WRITE_BACK` is set. Loads that miss, and stores that miss when allocation is on, follow the same path. If the victim line is dirty it is first written back as a whole block. The line is then refilled, and the access is replayed as a hit.

The CPU presents a request for one cycle while the controller is idle. It then waits for the single-cycle `cpu_ready` pulse. Memory reads and memory writes each use a request/acknowledge pair. The request stays high until the one-cycle acknowledge arrives.

Top module: `policy_cache_ctrl`

Addresses are word addresses split as {tag, index, offset}. With the default parameters the offset is bits [1:0], the index is bits [4:2] and the tag is bits [9:5]. Memory addresses are line addresses {tag, index}.

## Requirements
- R1: Reset clears every valid bit and every dirty bit, and holds `cpu_ready` low. After reset, the first access to any address reads a line from memory.
- R2: A load that hits returns the stored word with a one-cycle `cpu_ready` pulse and makes no memory read or write.
- R3: A load that misses refills the line through one block read at line address {tag, index}. It returns the word at the requested offset from the refilled data.
- R4: With `WRITE_BACK`=0, a store that hits updates the cached word and issues one memory write. That write carries a `mem_wr_mask` with only the bit of the word offset set. Other words in memory are untouched.
- R5: With `WRITE_BACK`=1, a store that hits updates only the cache, causes no memory traffic, and marks the line dirty.
- R6: With `WRITE_ALLOC`=1, a store that misses first refills the whole line with a block read and then merges the word as a hit. In write-back mode this leaves the line dirty.
- R7: With `WRITE_ALLOC`=0, a store that misses issues a single-word memory write only. Tags, valid bits and line data keep their values.
- R8: In write-back mode, replacing a dirty line first writes the whole old line to line address {old tag, index}, with all mask bits set. The refill read is issued only after that write is acknowledged.
- R9: Replacing a clean line issues no memory write.
- R10: With `WRITE_BACK`=0, no dirty state exists and no block write is ever issued. Every memory write carries exactly one mask bit.
- R11: `cpu_ready` is high for exactly one cycle per completed request. It stays low while any memory request is outstanding.
- R12: A request is captured only on a clock edge where the controller is idle. Requests raised while it is busy are ignored and cause no response or memory effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Request strobe, sampled when idle |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | WORD_W | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | WORD_W | Load result, valid with `cpu_ready` |
| mem_rd_req | output | 1 | Line read request, held until acknowledged |
| mem_rd_addr | output | ADDR_W-OFF_W | Line address of the read |
| mem_rd_ack | input | 1 | One-cycle read acknowledge |
| mem_rd_data | input | LINE_WORDS*WORD_W | Line data, valid with `mem_rd_ack` |
| mem_wr_req | output | 1 | Write request, held until acknowledged |
| mem_wr_addr | output | ADDR_W-OFF_W | Line address of the write |
| mem_wr_data | output | LINE_WORDS*WORD_W | Write data; word w sits at bits [w*WORD_W +: WORD_W] |
| mem_wr_mask | output | LINE_WORDS | Per-word write enables |
| mem_wr_ack | input | 1 | One-cycle write acknowledge |

## Verification
The bench targets the following cases.

- **Dirty line evicted by a load to another tag at the same index.** A design that forgets to mark lines dirty would lose the store silently. A design that refills before writing back would leave its write-back trace after the read.
- **Store-allocate that is evicted later.** Setting dirty only on a real hit, and not on the merged store, would drop the data.
- **No-allocate store that misses.** A design that installs the line would make a later load of the old resident line miss.
- **Write-through store.** The bench checks that the neighbouring memory words stay unchanged, which a full-line write with a wrong mask would break.
- **Request raised mid-refill.** A controller that captures requests while busy would corrupt the cache or produce a second ready pulse.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMP,
        ST_EVICT,
        ST_FILL,
        ST_WTHRU,
        ST_RESP
    } wpc_state_e;

    typedef enum logic [1:0] {
        PATH_RD_HIT,
        PATH_WR_HIT,
        PATH_BYPASS,
        PATH_REFILL
    } wpc_path_e;

    // Classify a looked-up request into the path the controller takes.
    function automatic wpc_path_e pick_path(input logic is_wr, input logic hit,
                                            input logic alloc);
        if (hit)
            return is_wr ? PATH_WR_HIT : PATH_RD_HIT;
        if (is_wr && !alloc)
            return PATH_BYPASS;
        return PATH_REFILL;
    endfunction

    // A victim must be written back only in write-back mode when modified.
    function automatic logic victim_needs_flush(input logic wb_mode, input logic valid,
                                                input logic dirty);
        return wb_mode && valid && dirty;
    endfunction

endpackage

// File: rtl/wpc_tag_store.sv
module wpc_tag_store #(
    parameter int LINES      = 8,
    parameter int TAG_W      = 5,
    parameter bit WRITE_BACK = 1'b1,
    localparam int IDX_W     = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             mark_dirty
);
    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            tag_q[idx]   <= fill_tag;
        end
    end

    assign rd_tag   = tag_q[idx];
    assign rd_valid = valid_q[idx];

    generate
        if (WRITE_BACK) begin : g_dirty
            logic [LINES-1:0] dirty_q;
            always_ff @(posedge clk) begin
                if (rst)
                    dirty_q <= '0;
                else if (fill_en)
                    dirty_q[idx] <= 1'b0;
                else if (mark_dirty)
                    dirty_q[idx] <= 1'b1;
            end
            assign rd_dirty = dirty_q[idx];

            // R5
            dirty_on_valid_chk: assert property (@(posedge clk) disable iff (rst)
                mark_dirty |-> valid_q[idx]);
            // R1
            dirty_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
                rd_dirty |-> rd_valid);
        end else begin : g_no_dirty
            assign rd_dirty = 1'b0;
            // R10
            no_mark_in_wt_chk: assert property (@(posedge clk) disable iff (rst)
                !mark_dirty);
        end
    endgenerate

endmodule

// File: rtl/wpc_data_store.sv
module wpc_data_store #(
    parameter int LINES      = 8,
    parameter int LINE_WORDS = 4,
    parameter int WORD_W     = 32,
    localparam int IDX_W     = $clog2(LINES),
    localparam int OFF_W     = $clog2(LINE_WORDS),
    localparam int LINE_W    = LINE_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx,
    output logic [LINE_W-1:0] rd_line,
    input  logic              fill_en,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              word_we,
    input  logic [OFF_W-1:0]  word_off,
    input  logic [WORD_W-1:0] word_data
);
    logic [LINE_W-1:0] line_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) line_q[i] <= '0;
        end else if (fill_en) begin
            line_q[idx] <= fill_line;
        end else if (word_we) begin
            line_q[idx][word_off*WORD_W +: WORD_W] <= word_data;
        end
    end

    assign rd_line = line_q[idx];

    // R6
    fill_merge_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fill_en && word_we));

endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
    import wpc_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int WORD_W      = 32,
    parameter int LINE_WORDS  = 4,
    parameter int LINES       = 8,
    parameter bit WRITE_BACK  = 1'b1,
    parameter bit WRITE_ALLOC = 1'b1,
    localparam int OFF_W      = $clog2(LINE_WORDS),
    localparam int IDX_W      = $clog2(LINES),
    localparam int TAG_W      = ADDR_W - OFF_W - IDX_W,
    localparam int BADDR_W    = ADDR_W - OFF_W,
    localparam int LINE_W     = LINE_WORDS * WORD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_req_valid,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [WORD_W-1:0]  cpu_wdata,
    output logic               cpu_ready,
    output logic [WORD_W-1:0]  cpu_rdata,
    output logic               mem_rd_req,
    output logic [BADDR_W-1:0] mem_rd_addr,
    input  logic               mem_rd_ack,
    output logic               mem_wr_req,
    output logic [BADDR_W-1:0] mem_wr_addr,
    output logic [LINE_W-1:0]  mem_wr_data,
    output logic [LINE_WORDS-1:0] mem_wr_mask,
    input  logic               mem_wr_ack,
    output logic [IDX_W-1:0]   line_idx,
    output logic [OFF_W-1:0]   line_off,
    output logic [TAG_W-1:0]   req_tag,
    output logic [WORD_W-1:0]  req_wdata,
    input  logic [TAG_W-1:0]   ts_tag,
    input  logic               ts_valid,
    input  logic               ts_dirty,
    input  logic [LINE_W-1:0]  ds_line,
    output logic               fill_en,
    output logic               word_we,
    output logic               mark_dirty
);
    wpc_state_e        st_q, st_d;
    logic              req_we_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [WORD_W-1:0] req_wdata_q;
    logic [WORD_W-1:0] resp_q;
    logic              hit;
    wpc_path_e         path;
    logic [WORD_W-1:0] hit_word;

    assign line_off  = req_addr_q[OFF_W-1:0];
    assign line_idx  = req_addr_q[OFF_W +: IDX_W];
    assign req_tag   = req_addr_q[ADDR_W-1 -: TAG_W];
    assign req_wdata = req_wdata_q;
    assign hit       = ts_valid && (ts_tag == req_tag);
    assign path      = pick_path(req_we_q, hit, WRITE_ALLOC);
    assign hit_word  = ds_line[line_off*WORD_W +: WORD_W];
    assign cpu_rdata = resp_q;

    always_comb begin
        st_d        = st_q;
        cpu_ready   = 1'b0;
        mem_rd_req  = 1'b0;
        mem_rd_addr = {req_tag, line_idx};
        mem_wr_req  = 1'b0;
        mem_wr_addr = {req_tag, line_idx};
        mem_wr_data = {LINE_WORDS{req_wdata_q}};
        mem_wr_mask = '0;
        fill_en     = 1'b0;
        word_we     = 1'b0;
        mark_dirty  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (cpu_req_valid) st_d = ST_CMP;
            end
            ST_CMP: begin
                unique case (path)
                    PATH_RD_HIT: st_d = ST_RESP;
                    PATH_WR_HIT: begin
                        word_we    = 1'b1;
                        mark_dirty = WRITE_BACK;
                        st_d       = WRITE_BACK ? ST_RESP : ST_WTHRU;
                    end
                    PATH_BYPASS: st_d = ST_WTHRU;
                    PATH_REFILL: begin
                        st_d = victim_needs_flush(WRITE_BACK, ts_valid, ts_dirty)
                               ? ST_EVICT : ST_FILL;
                    end
                    default: st_d = ST_IDLE;
                endcase
            end
            ST_EVICT: begin
                mem_wr_req  = 1'b1;
                mem_wr_addr = {ts_tag, line_idx};
                mem_wr_data = ds_line;
                mem_wr_mask = '1;
                if (mem_wr_ack) st_d = ST_FILL;
            end
            ST_FILL: begin
                mem_rd_req = 1'b1;
                if (mem_rd_ack) begin
                    fill_en = 1'b1;
                    st_d    = ST_CMP;
                end
            end
            ST_WTHRU: begin
                mem_wr_req            = 1'b1;
                mem_wr_mask[line_off] = 1'b1;
                if (mem_wr_ack) st_d = ST_RESP;
            end
            ST_RESP: begin
                cpu_ready = 1'b1;
                st_d      = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            req_we_q    <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            resp_q      <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && cpu_req_valid) begin
                req_we_q    <= cpu_we;
                req_addr_q  <= cpu_addr;
                req_wdata_q <= cpu_wdata;
            end
            if (st_q == ST_CMP && path == PATH_RD_HIT)
                resp_q <= hit_word;
        end
    end

    // R11
    ready_single_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);
    // R11
    ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req || mem_wr_req) |-> !cpu_ready);
    // R8
    one_mem_op_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_req && mem_wr_req));
    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));
    // R4
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr)));
    // R12
    busy_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE) |=> $stable(req_addr_q));

    generate
        if (!WRITE_BACK) begin : g_wt_chk
            // R10
            single_word_wr_chk: assert property (@(posedge clk) disable iff (rst)
                mem_wr_req |-> ($countones(mem_wr_mask) == 1));
        end
    endgenerate

endmodule

// File: rtl/policy_cache_ctrl.sv
module policy_cache_ctrl #(
    parameter int ADDR_W      = 10,
    parameter int WORD_W      = 32,
    parameter int LINE_WORDS  = 4,
    parameter int LINES       = 8,
    parameter bit WRITE_BACK  = 1'b1,
    parameter bit WRITE_ALLOC = 1'b1,
    localparam int OFF_W      = $clog2(LINE_WORDS),
    localparam int IDX_W      = $clog2(LINES),
    localparam int TAG_W      = ADDR_W - OFF_W - IDX_W,
    localparam int BADDR_W    = ADDR_W - OFF_W,
    localparam int LINE_W     = LINE_WORDS * WORD_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cpu_req_valid,
    input  logic                  cpu_we,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [WORD_W-1:0]     cpu_wdata,
    output logic                  cpu_ready,
    output logic [WORD_W-1:0]     cpu_rdata,
    output logic                  mem_rd_req,
    output logic [BADDR_W-1:0]    mem_rd_addr,
    input  logic                  mem_rd_ack,
    input  logic [LINE_W-1:0]     mem_rd_data,
    output logic                  mem_wr_req,
    output logic [BADDR_W-1:0]    mem_wr_addr,
    output logic [LINE_W-1:0]     mem_wr_data,
    output logic [LINE_WORDS-1:0] mem_wr_mask,
    input  logic                  mem_wr_ack
);
    logic [IDX_W-1:0]  line_idx;
    logic [OFF_W-1:0]  line_off;
    logic [TAG_W-1:0]  req_tag;
    logic [WORD_W-1:0] req_wdata;
    logic [TAG_W-1:0]  ts_tag;
    logic              ts_valid;
    logic              ts_dirty;
    logic [LINE_W-1:0] ds_line;
    logic              fill_en;
    logic              word_we;
    logic              mark_dirty;

    wpc_ctrl #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .LINES(LINES),
        .WRITE_BACK(WRITE_BACK), .WRITE_ALLOC(WRITE_ALLOC)
    ) ctrl_i (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_mask(mem_wr_mask), .mem_wr_ack(mem_wr_ack),
        .line_idx(line_idx), .line_off(line_off), .req_tag(req_tag),
        .req_wdata(req_wdata), .ts_tag(ts_tag), .ts_valid(ts_valid),
        .ts_dirty(ts_dirty), .ds_line(ds_line), .fill_en(fill_en),
        .word_we(word_we), .mark_dirty(mark_dirty)
    );

    wpc_tag_store #(
        .LINES(LINES), .TAG_W(TAG_W), .WRITE_BACK(WRITE_BACK)
    ) tags_i (
        .clk(clk), .rst(rst), .idx(line_idx), .rd_tag(ts_tag), .rd_valid(ts_valid),
        .rd_dirty(ts_dirty), .fill_en(fill_en), .fill_tag(req_tag),
        .mark_dirty(mark_dirty)
    );

    wpc_data_store #(
        .LINES(LINES), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)
    ) data_i (
        .clk(clk), .rst(rst), .idx(line_idx), .rd_line(ds_line),
        .fill_en(fill_en), .fill_line(mem_rd_data), .word_we(word_we),
        .word_off(line_off), .word_data(req_wdata)
    );

endmodule

// File: tb/policy_cache_ctrl_tb_top.sv
module tb_line_mem #(
    parameter int ADDR_W     = 10,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int LAT        = 2,
    localparam int OFF_W     = $clog2(LINE_WORDS),
    localparam int BADDR_W   = ADDR_W - OFF_W,
    localparam int LINE_W    = LINE_WORDS * WORD_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_req,
    input  logic [BADDR_W-1:0]    rd_addr,
    output logic                  rd_ack,
    output logic [LINE_W-1:0]     rd_data,
    input  logic                  wr_req,
    input  logic [BADDR_W-1:0]    wr_addr,
    input  logic [LINE_W-1:0]     wr_data,
    input  logic [LINE_WORDS-1:0] wr_mask,
    output logic                  wr_ack,
    input  logic [ADDR_W-1:0]     peek_addr,
    output logic [WORD_W-1:0]     peek_data,
    output int                    rd_cnt,
    output int                    blk_cnt,
    output int                    word_cnt,
    output int                    rd_seq,
    output int                    blk_seq,
    output logic [BADDR_W-1:0]    blk_addr
);
    logic [WORD_W-1:0] mem [2**ADDR_W];
    int rd_wait, wr_wait, seq;

    assign peek_data = mem[peek_addr];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 2**ADDR_W; i++) mem[i] <= WORD_W'(32'hC0DE_0000 | i);
            rd_ack <= 1'b0; wr_ack <= 1'b0; rd_data <= '0;
            rd_wait <= 0; wr_wait <= 0; seq <= 1;
            rd_cnt <= 0; blk_cnt <= 0; word_cnt <= 0; rd_seq <= 0; blk_seq <= 0;
            blk_addr <= '0;
        end else begin
            rd_ack <= 1'b0;
            wr_ack <= 1'b0;
            if (rd_req && !rd_ack) begin
                if (rd_wait == LAT) begin
                    rd_ack  <= 1'b1;
                    rd_wait <= 0;
                    for (int w = 0; w < LINE_WORDS; w++)
                        rd_data[w*WORD_W +: WORD_W] <= mem[{rd_addr, w[OFF_W-1:0]}];
                    rd_cnt <= rd_cnt + 1;
                    rd_seq <= seq;
                    seq    <= seq + 1;
                end else rd_wait <= rd_wait + 1;
            end
            if (wr_req && !wr_ack) begin
                if (wr_wait == LAT) begin
                    wr_ack  <= 1'b1;
                    wr_wait <= 0;
                    for (int w = 0; w < LINE_WORDS; w++)
                        if (wr_mask[w]) mem[{wr_addr, w[OFF_W-1:0]}] <= wr_data[w*WORD_W +: WORD_W];
                    if (wr_mask == '1) begin
                        blk_cnt  <= blk_cnt + 1;
                        blk_seq  <= seq;
                        blk_addr <= wr_addr;
                    end else word_cnt <= word_cnt + 1;
                    seq <= seq + 1;
                end else wr_wait <= wr_wait + 1;
            end
        end
    end
endmodule

module policy_cache_ctrl_tb_top;
    localparam int AW = 10, WW = 32, LW = 4, BW = 8, LINEW = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          cpu_req [2];
    logic          cpu_we [2];
    logic [AW-1:0] cpu_addr [2];
    logic [WW-1:0] cpu_wdata [2];
    logic          cpu_ready [2];
    logic [WW-1:0] cpu_rdata [2];
    logic          m_rd_req [2], m_rd_ack [2], m_wr_req [2], m_wr_ack [2];
    logic [BW-1:0] m_rd_addr [2], m_wr_addr [2], m_blk_addr [2];
    logic [LINEW-1:0] m_rd_data [2], m_wr_data [2];
    logic [LW-1:0] m_wr_mask [2];
    logic [AW-1:0] peek_addr [2];
    logic [WW-1:0] peek_data [2];
    int rd_cnt [2], blk_cnt [2], word_cnt [2], rd_seq [2], blk_seq [2];

    int tests = 0;
    int fails = 0;

    policy_cache_ctrl #(.WRITE_BACK(1'b1), .WRITE_ALLOC(1'b1)) dut_i (
        .clk(clk), .rst(rst), .cpu_req_valid(cpu_req[0]), .cpu_we(cpu_we[0]),
        .cpu_addr(cpu_addr[0]), .cpu_wdata(cpu_wdata[0]), .cpu_ready(cpu_ready[0]),
        .cpu_rdata(cpu_rdata[0]), .mem_rd_req(m_rd_req[0]), .mem_rd_addr(m_rd_addr[0]),
        .mem_rd_ack(m_rd_ack[0]), .mem_rd_data(m_rd_data[0]), .mem_wr_req(m_wr_req[0]),
        .mem_wr_addr(m_wr_addr[0]), .mem_wr_data(m_wr_data[0]),
        .mem_wr_mask(m_wr_mask[0]), .mem_wr_ack(m_wr_ack[0]));

    policy_cache_ctrl #(.WRITE_BACK(1'b0), .WRITE_ALLOC(1'b0)) dut_wt_i (
        .clk(clk), .rst(rst), .cpu_req_valid(cpu_req[1]), .cpu_we(cpu_we[1]),
        .cpu_addr(cpu_addr[1]), .cpu_wdata(cpu_wdata[1]), .cpu_ready(cpu_ready[1]),
        .cpu_rdata(cpu_rdata[1]), .mem_rd_req(m_rd_req[1]), .mem_rd_addr(m_rd_addr[1]),
        .mem_rd_ack(m_rd_ack[1]), .mem_rd_data(m_rd_data[1]), .mem_wr_req(m_wr_req[1]),
        .mem_wr_addr(m_wr_addr[1]), .mem_wr_data(m_wr_data[1]),
        .mem_wr_mask(m_wr_mask[1]), .mem_wr_ack(m_wr_ack[1]));

    for (genvar g = 0; g < 2; g++) begin : g_mem
        tb_line_mem mem_i (
            .clk(clk), .rst(rst), .rd_req(m_rd_req[g]), .rd_addr(m_rd_addr[g]),
            .rd_ack(m_rd_ack[g]), .rd_data(m_rd_data[g]), .wr_req(m_wr_req[g]),
            .wr_addr(m_wr_addr[g]), .wr_data(m_wr_data[g]), .wr_mask(m_wr_mask[g]),
            .wr_ack(m_wr_ack[g]), .peek_addr(peek_addr[g]), .peek_data(peek_data[g]),
            .rd_cnt(rd_cnt[g]), .blk_cnt(blk_cnt[g]), .word_cnt(word_cnt[g]),
            .rd_seq(rd_seq[g]), .blk_seq(blk_seq[g]), .blk_addr(m_blk_addr[g]));
    end

    function automatic logic [AW-1:0] mk(input int t, input int i, input int o);
        return AW'(t * 32 + i * 4 + o);
    endfunction

    function automatic logic [WW-1:0] init_w(input logic [AW-1:0] a);
        return 32'hC0DE_0000 | {22'b0, a};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic peek(input int k, input logic [AW-1:0] a, output logic [WW-1:0] v);
        peek_addr[k] = a;
        #1;
        v = peek_data[k];
    endtask

    task automatic access(input int k, input logic we, input logic [AW-1:0] a,
                          input logic [WW-1:0] wd, output logic [WW-1:0] rd);
        int n;
        @(negedge clk);
        cpu_req[k] = 1'b1; cpu_we[k] = we; cpu_addr[k] = a; cpu_wdata[k] = wd;
        @(negedge clk);
        cpu_req[k] = 1'b0;
        n = 0;
        while (!cpu_ready[k] && n < 300) begin
            @(negedge clk);
            n++;
        end
        check("R11 ready pulse seen", 32'(cpu_ready[k]), 32'd1);
        rd = cpu_rdata[k];
        @(negedge clk);
        check("R11 ready lasts one cycle", 32'(cpu_ready[k]), 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 ready low after reset", 32'(cpu_ready[0]), 32'd0);
        check("R1 no traffic after reset", 32'(rd_cnt[0] + blk_cnt[1] + word_cnt[0]), 32'd0);
    endtask

    task automatic t_wb_hits();
        logic [WW-1:0] v;
        int r0, b0, w0;
        r0 = rd_cnt[0];
        access(0, 1'b0, mk(1, 0, 0), '0, v);
        check("R1 first access refills", 32'(rd_cnt[0] - r0), 32'd1);
        check("R3 read miss data", v, init_w(mk(1, 0, 0)));
        r0 = rd_cnt[0]; b0 = blk_cnt[0]; w0 = word_cnt[0];
        access(0, 1'b0, mk(1, 0, 1), '0, v);
        check("R2 read hit data", v, init_w(mk(1, 0, 1)));
        check("R2 read hit no traffic", 32'(rd_cnt[0] - r0 + blk_cnt[0] - b0 + word_cnt[0] - w0), 32'd0);
        access(0, 1'b1, mk(1, 0, 2), 32'h1111_AAAA, v);
        check("R5 write hit no traffic", 32'(rd_cnt[0] - r0 + blk_cnt[0] - b0 + word_cnt[0] - w0), 32'd0);
        peek(0, mk(1, 0, 2), v);
        check("R5 memory not written", v, init_w(mk(1, 0, 2)));
        access(0, 1'b0, mk(1, 0, 2), '0, v);
        check("R2 read after write hit", v, 32'h1111_AAAA);
    endtask

    task automatic t_wb_evict();
        logic [WW-1:0] v;
        int r0, b0;
        r0 = rd_cnt[0]; b0 = blk_cnt[0];
        access(0, 1'b0, mk(2, 0, 0), '0, v);
        check("R8 dirty victim written back", 32'(blk_cnt[0] - b0), 32'd1);
        check("R8 write-back line address", 32'(m_blk_addr[0]), 32'(mk(1, 0, 0) >> 2));
        check("R8 write-back before refill", 32'(blk_seq[0] < rd_seq[0]), 32'd1);
        peek(0, mk(1, 0, 2), v);
        check("R8 dirty word reached memory", v, 32'h1111_AAAA);
        check("R3 refill count", 32'(rd_cnt[0] - r0), 32'd1);
        check("R3 data after eviction", cpu_rdata[0], init_w(mk(2, 0, 0)));
        b0 = blk_cnt[0];
        access(0, 1'b0, mk(1, 0, 2), '0, v);
        check("R9 clean victim not written", 32'(blk_cnt[0] - b0), 32'd0);
        check("R3 refetch sees written-back word", v, 32'h1111_AAAA);
    endtask

    task automatic t_wb_alloc();
        logic [WW-1:0] v;
        int r0, b0, w0;
        r0 = rd_cnt[0]; b0 = blk_cnt[0]; w0 = word_cnt[0];
        access(0, 1'b1, mk(6, 1, 1), 32'h2222_BBBB, v);
        check("R6 write miss refills line", 32'(rd_cnt[0] - r0), 32'd1);
        check("R6 write miss no word write", 32'(word_cnt[0] - w0 + blk_cnt[0] - b0), 32'd0);
        r0 = rd_cnt[0];
        access(0, 1'b0, mk(6, 1, 1), '0, v);
        check("R6 merged word hits", v, 32'h2222_BBBB);
        access(0, 1'b0, mk(6, 1, 3), '0, v);
        check("R6 rest of line filled", v, init_w(mk(6, 1, 3)));
        check("R6 hits after allocate", 32'(rd_cnt[0] - r0), 32'd0);
        b0 = blk_cnt[0];
        access(0, 1'b0, mk(7, 1, 0), '0, v);
        check("R6 allocated line was dirty", 32'(blk_cnt[0] - b0), 32'd1);
        peek(0, mk(6, 1, 1), v);
        check("R6 merged word written back", v, 32'h2222_BBBB);
    endtask

    task automatic t_busy_ignore();
        logic [WW-1:0] v;
        int r0, w0, b0, n, extra;
        r0 = rd_cnt[0]; w0 = word_cnt[0]; b0 = blk_cnt[0];
        @(negedge clk);
        cpu_req[0] = 1'b1; cpu_we[0] = 1'b0; cpu_addr[0] = mk(3, 2, 0);
        @(negedge clk);
        cpu_req[0] = 1'b0;
        @(negedge clk);
        cpu_req[0] = 1'b1; cpu_we[0] = 1'b1; cpu_wdata[0] = 32'hBAD0_0001;
        @(negedge clk);
        cpu_req[0] = 1'b0;
        n = 0;
        while (!cpu_ready[0] && n < 300) begin
            @(negedge clk);
            n++;
        end
        check("R12 first request completes", 32'(cpu_ready[0]), 32'd1);
        extra = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (cpu_ready[0]) extra++;
        end
        check("R12 busy request gives no response", 32'(extra), 32'd0);
        check("R12 busy request no memory write", 32'(word_cnt[0] - w0 + blk_cnt[0] - b0), 32'd0);
        r0 = rd_cnt[0];
        access(0, 1'b0, mk(3, 2, 0), '0, v);
        check("R12 cached word unchanged", v, init_w(mk(3, 2, 0)));
        check("R12 line still resident", 32'(rd_cnt[0] - r0), 32'd0);
    endtask

    task automatic t_wt_noalloc();
        logic [WW-1:0] v;
        int r0, b0, w0;
        access(1, 1'b0, mk(1, 0, 0), '0, v);
        check("R3 wt read miss data", v, init_w(mk(1, 0, 0)));
        r0 = rd_cnt[1]; w0 = word_cnt[1];
        access(1, 1'b1, mk(1, 0, 1), 32'h3333_CCCC, v);
        check("R4 write hit sends one word", 32'(word_cnt[1] - w0), 32'd1);
        peek(1, mk(1, 0, 1), v);
        check("R4 memory word updated", v, 32'h3333_CCCC);
        peek(1, mk(1, 0, 0), v);
        check("R4 neighbour word untouched", v, init_w(mk(1, 0, 0)));
        access(1, 1'b0, mk(1, 0, 1), '0, v);
        check("R4 cache word updated", v, 32'h3333_CCCC);
        check("R4 no read traffic", 32'(rd_cnt[1] - r0), 32'd0);
        w0 = word_cnt[1];
        access(1, 1'b1, mk(4, 0, 2), 32'h4444_DDDD, v);
        check("R7 miss writes one word", 32'(word_cnt[1] - w0), 32'd1);
        check("R7 miss does not refill", 32'(rd_cnt[1] - r0), 32'd0);
        peek(1, mk(4, 0, 2), v);
        check("R7 memory holds store", v, 32'h4444_DDDD);
        access(1, 1'b0, mk(1, 0, 1), '0, v);
        check("R7 resident line kept", v, 32'h3333_CCCC);
        check("R7 resident line still hits", 32'(rd_cnt[1] - r0), 32'd0);
        b0 = blk_cnt[1];
        access(1, 1'b0, mk(4, 0, 2), '0, v);
        check("R7 later read misses", 32'(rd_cnt[1] - r0), 32'd1);
        check("R7 later read data", v, 32'h4444_DDDD);
        check("R10 no block write on eviction", 32'(blk_cnt[1] - b0), 32'd0);
        check("R10 no block writes at all", 32'(blk_cnt[1]), 32'd0);
    endtask

    initial begin
        for (int k = 0; k < 2; k++) begin
            cpu_req[k] = 1'b0; cpu_we[k] = 1'b0; cpu_addr[k] = '0;
            cpu_wdata[k] = '0; peek_addr[k] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_wb_hits();
        t_wb_evict();
        t_wb_alloc();
        t_busy_ignore();
        t_wt_noalloc();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule